// File: doc/BRIEF.md
# Serial Steepest-Descent Channel Estimate Updater

This block refines a multiuser channel estimate by one fixed-step steepest-descent iteration each time it is started. The estimate is a ROWS x COLS matrix of signed 8-bit elements, held as two planes, real and imaginary. On a start strobe the block walks the matrix and forms, for every element, the error term (A·Rbb − Rbr), scales it down by a power-of-two step and subtracts it from the old element. The step is applied as an arithmetic right shift by the parameter SHIFT.

The autocorrelation matrix Rbb (COLS x COLS, real, signed 8-bit) and the cross-correlation matrix Rbr (ROWS x COLS, real and imaginary planes, signed 16-bit) belong to the surrounding logic. The block reaches them through combinational read ports that return data in the same cycle as the address. Each plane has one multiplier, and both planes share the same Rbb read. Every new element is computed from the old estimate and written to a shadow buffer. The whole matrix is committed at once, and a one-cycle done pulse marks the commit. A load port fills the estimate before the first iteration, and a read port returns any element.

Top module: `sd_chan_est_update`

## Requirements
- R1: After a synchronous active-low reset, every estimate element reads 0 in both planes and done is low.
- R2: While no update is running, load_en writes load_re and load_im into element load_idx, where the index is row*COLS+col. rd_re and rd_im show element rd_idx combinationally, in the same cycle.
- R3: For element (i,j), the accumulator starts at 0 and adds A[i][k]·Rbb[k][j] for k = 0..COLS-1 in order. Each product is 8x8 signed, and the running sum saturates to [-32768, 32767] after every addition. Rbb is addressed at rbb_addr = k*COLS+j and Rbr at rbr_addr = i*COLS+j.
- R4: The error is the accumulator minus Rbr[i][j], saturated to 16 bits. The step is the error shifted arithmetically right by SHIFT (rounding toward minus infinity) and then saturated to [-128, 127].
- R5: The new element is the old element minus the step, saturated to [-128, 127].
- R6: All new elements are computed from the estimate as it stood at start. The estimate does not change while an update runs, and every element changes at the same clock edge, the one at which done rises.
- R7: The real and imaginary planes are updated independently, with identical arithmetic against their own Rbr plane and a shared Rbb.
- R8: The clock edge that samples start is edge 0. done is high for exactly one cycle, after edge ROWS*COLS*(COLS+1)+1.
- R9: Start and load_en pulses that arrive while an update runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one update pass |
| load_en | input | 1 | Write one estimate element |
| load_idx | input | IDX_W | Element index for load (row*COLS+col) |
| load_re | input | 8 | Real value to load |
| load_im | input | 8 | Imaginary value to load |
| rbb_addr | output | RBB_W | Rbb element address (k*COLS+j) |
| rbb_data | input | 8 | Rbb element, signed |
| rbr_addr | output | IDX_W | Rbr element address (i*COLS+j) |
| rbr_re | input | 16 | Rbr real element, signed |
| rbr_im | input | 16 | Rbr imaginary element, signed |
| rd_idx | input | IDX_W | Estimate read index |
| rd_re | output | 8 | Estimate real element at rd_idx |
| rd_im | output | 8 | Estimate imaginary element at rd_idx |
| done | output | 1 | One-cycle pulse at commit |

## Verification
The saturation points are hard to reach from the ports, because the accumulator clamp can only be seen through the chain of shift, clamp and subtract. The bench loads extreme matrices, such as all -128 against an all -128 Rbb, so that both the 16-bit clamp and the final 8-bit clamp are driven in both directions. It then runs a long sequence of chained passes with pseudo-random matrices, compared with a reference computed in the bench. Ignoring pulses during a pass is shown by injecting start and load mid-pass, then checking that the element being read stays unchanged and that done arrives on its nominal cycle.

// File: rtl/sd_est_pkg.sv
// Package: shared types and saturating helpers for the steepest-descent
// channel estimate updater. Assumes two's-complement signed arithmetic.
package sd_est_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACC    = 2'd1,
        S_FIN    = 2'd2,
        S_COMMIT = 2'd3
    } sd_state_e;

    // Clamp an 18-bit signed value into the 16-bit signed range.
    function automatic logic signed [15:0] sat16(input logic signed [17:0] v);
        if (v > 18'sd32767)
            return 16'sh7fff;
        else if (v < -18'sd32768)
            return 16'sh8000;
        else
            return v[15:0];
    endfunction

    // Clamp an 18-bit signed value into the 8-bit signed range.
    function automatic logic signed [7:0] sat8(input logic signed [17:0] v);
        if (v > 18'sd127)
            return 8'sh7f;
        else if (v < -18'sd128)
            return 8'sh80;
        else
            return v[7:0];
    endfunction

endpackage

// File: rtl/sd_seq.sv
// Sequencer: walks elements (i,j) in row-major order, and for each one
// runs COLS accumulate cycles and then one finalize cycle. After the last
// element it runs one commit cycle. Assumes ROWS >= 2 and COLS >= 2.
module sd_seq
    import sd_est_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int IDX_W = $clog2(ROWS * COLS),
    parameter int RBB_W = $clog2(COLS * COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             acc_clr,
    output logic             acc_en,
    output logic             sh_we,
    output logic             commit,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] a_idx,
    output logic [IDX_W-1:0] el_idx,
    output logic [RBB_W-1:0] rbb_idx
);
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);

    sd_state_e       state;
    logic [RW-1:0]   row_q;
    logic [CW-1:0]   col_q;
    logic [CW-1:0]   k_q;

    // State and counters: advance k, then column, then row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            row_q <= '0;
            col_q <= '0;
            k_q   <= '0;
            done  <= 1'b0;
        end else begin
            done <= (state == S_COMMIT);
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state <= S_ACC;
                        row_q <= '0;
                        col_q <= '0;
                        k_q   <= '0;
                    end
                end
                S_ACC: begin
                    if (k_q == CW'(COLS - 1)) begin
                        k_q   <= '0;
                        state <= S_FIN;
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
                S_FIN: begin
                    if (col_q == CW'(COLS - 1)) begin
                        col_q <= '0;
                        if (row_q == RW'(ROWS - 1)) begin
                            row_q <= '0;
                            state <= S_COMMIT;
                        end else begin
                            row_q <= row_q + 1'b1;
                            state <= S_ACC;
                        end
                    end else begin
                        col_q <= col_q + 1'b1;
                        state <= S_ACC;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Control strobes and addresses derived from the state.
    always_comb begin
        acc_en  = (state == S_ACC);
        acc_clr = (state == S_IDLE) || (state == S_FIN);
        sh_we   = (state == S_FIN);
        commit  = (state == S_COMMIT);
        busy    = (state != S_IDLE);
        el_idx  = IDX_W'(row_q * COLS + col_q);
        rbb_idx = RBB_W'(k_q * COLS + col_q);
        a_idx   = (state == S_FIN) ? el_idx : IDX_W'(row_q * COLS + k_q);
    end

endmodule

// File: rtl/sd_lane.sv
// Arithmetic lane for one plane: a single 8x8 multiplier feeding a
// saturating 16-bit accumulator, then error, shift, clamp and subtract.
// Assumes a_val holds the old element itself during the finalize cycle.
module sd_lane
    import sd_est_pkg::*;
#(
    parameter int SHIFT = 3,
    parameter int RBR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_clr,
    input  logic                    acc_en,
    input  logic signed [7:0]       a_val,
    input  logic signed [7:0]       rbb_val,
    input  logic signed [RBR_W-1:0] rbr_val,
    output logic signed [7:0]       new_val
);
    logic signed [15:0] acc_q;
    logic signed [15:0] prod;
    logic signed [15:0] err;
    logic signed [15:0] step;
    logic signed [7:0]  step8;

    assign prod = a_val * rbb_val;

    // Accumulator: cleared between elements, saturating on each add.
    always_ff @(posedge clk) begin
        if (!rst_n || acc_clr)
            acc_q <= '0;
        else if (acc_en)
            acc_q <= sat16({{2{acc_q[15]}}, acc_q} + {{2{prod[15]}}, prod});
    end

    // Finalize path: error, arithmetic shift, step clamp, subtract.
    always_comb begin
        err     = sat16({{2{acc_q[15]}}, acc_q} - 18'(rbr_val));
        step    = err >>> SHIFT;
        step8   = sat8({{2{step[15]}}, step});
        new_val = sat8({{10{a_val[7]}}, a_val} - {{10{step8[7]}}, step8});
    end

endmodule

// File: rtl/sd_store.sv
// Estimate storage for one plane: a live array plus a shadow array.
// The commit copies the whole shadow into the live array at once and
// takes priority over a load. Assumes loads are gated off while busy.
module sd_store #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [IDX_W-1:0]        load_idx,
    input  logic signed [7:0]       load_val,
    input  logic                    sh_we,
    input  logic [IDX_W-1:0]        sh_idx,
    input  logic signed [7:0]       sh_val,
    input  logic                    commit,
    input  logic [IDX_W-1:0]        a_idx,
    output logic signed [7:0]       a_val,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic signed [7:0]       rd_val
);
    logic signed [7:0] est_q [DEPTH];
    logic signed [7:0] shd_q [DEPTH];

    // Live estimate: reset, commit of the shadow, or a single load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < DEPTH; n++) est_q[n] <= '0;
        end else if (commit) begin
            for (int n = 0; n < DEPTH; n++) est_q[n] <= shd_q[n];
        end else if (load_en) begin
            est_q[load_idx] <= load_val;
        end
    end

    // Shadow buffer: collects the new elements during a pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < DEPTH; n++) shd_q[n] <= '0;
        end else if (sh_we) begin
            shd_q[sh_idx] <= sh_val;
        end
    end

    assign a_val  = est_q[a_idx];
    assign rd_val = est_q[rd_idx];

endmodule

// File: rtl/sd_chan_est_update.sv
// Top: one steepest-descent pass A <- A - 2^-SHIFT (A*Rbb - Rbr) per start.
// Two identical lanes (real, imaginary) share the sequencer and the Rbb
// read. The Rbb/Rbr read ports are combinational (same-cycle data).
module sd_chan_est_update #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int SHIFT = 3,
    parameter int RBR_W = 16,
    localparam int DEPTH = ROWS * COLS,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int RBB_W = $clog2(COLS * COLS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    load_en,
    input  logic [IDX_W-1:0]        load_idx,
    input  logic signed [7:0]       load_re,
    input  logic signed [7:0]       load_im,
    output logic [RBB_W-1:0]        rbb_addr,
    input  logic signed [7:0]       rbb_data,
    output logic [IDX_W-1:0]        rbr_addr,
    input  logic signed [RBR_W-1:0] rbr_re,
    input  logic signed [RBR_W-1:0] rbr_im,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic signed [7:0]       rd_re,
    output logic signed [7:0]       rd_im,
    output logic                    done
);
    logic             acc_clr, acc_en, sh_we, commit, busy;
    logic [IDX_W-1:0] a_idx, el_idx;

    logic signed [7:0]       ld_v  [2];
    logic signed [RBR_W-1:0] rbr_v [2];
    logic signed [7:0]       rd_v  [2];

    assign ld_v[0]  = load_re;
    assign ld_v[1]  = load_im;
    assign rbr_v[0] = rbr_re;
    assign rbr_v[1] = rbr_im;
    assign rd_re    = rd_v[0];
    assign rd_im    = rd_v[1];
    assign rbr_addr = el_idx;

    sd_seq #(
        .ROWS(ROWS), .COLS(COLS), .IDX_W(IDX_W), .RBB_W(RBB_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .acc_clr(acc_clr), .acc_en(acc_en), .sh_we(sh_we),
        .commit(commit), .busy(busy), .done(done),
        .a_idx(a_idx), .el_idx(el_idx), .rbb_idx(rbb_addr)
    );

    for (genvar g = 0; g < 2; g++) begin : g_plane
        logic signed [7:0] a_val;
        logic signed [7:0] new_val;

        sd_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
            .clk(clk), .rst_n(rst_n),
            .load_en(load_en && !busy), .load_idx(load_idx), .load_val(ld_v[g]),
            .sh_we(sh_we), .sh_idx(el_idx), .sh_val(new_val),
            .commit(commit),
            .a_idx(a_idx), .a_val(a_val),
            .rd_idx(rd_idx), .rd_val(rd_v[g])
        );

        sd_lane #(.SHIFT(SHIFT), .RBR_W(RBR_W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .acc_clr(acc_clr), .acc_en(acc_en),
            .a_val(a_val), .rbb_val(rbb_data), .rbr_val(rbr_v[g]),
            .new_val(new_val)
        );
    end

endmodule

// File: rtl/sd_chan_est_update_chk.sv
// Checker for sd_chan_est_update: protocol and stability properties,
// bound into every instance of the top module.
module sd_chan_est_update_chk #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int IDX_W = $clog2(ROWS * COLS),
    localparam int RBB_W = $clog2(COLS * COLS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [IDX_W-1:0] rd_idx,
    input logic [7:0]       rd_re,
    input logic [7:0]       rd_im,
    input logic [RBB_W-1:0] rbb_addr,
    input logic [IDX_W-1:0] rbr_addr
);
    // R8: done is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done rises only at the end of a running pass.
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R8: start while idle launches a pass.
    p_start_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6, R9: estimate frozen while a pass runs (loads ignored too).
    p_est_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(rd_idx)) |-> ($stable(rd_re) && $stable(rd_im)));

    // R3: Rbb and Rbr addresses stay inside their matrices.
    p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rbb_addr) < COLS * COLS) && (int'(rbr_addr) < ROWS * COLS));

endmodule

bind sd_chan_est_update sd_chan_est_update_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .rd_idx(rd_idx), .rd_re(rd_re), .rd_im(rd_im),
    .rbb_addr(rbb_addr), .rbr_addr(rbr_addr)
);

// File: tb/sd_chan_est_update_tb.sv
// Bench: small 2x3 configuration, reference arithmetic in integers.
module sd_chan_est_update_tb;
    localparam int ROWS = 2;
    localparam int COLS = 3;
    localparam int SH   = 2;
    localparam int E    = ROWS * COLS;
    localparam int NB   = COLS * COLS;
    localparam int IW   = $clog2(E);
    localparam int BW   = $clog2(NB);
    localparam int PASS_CYC = E * (COLS + 1) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic load_en = 1'b0;
    logic [IW-1:0] load_idx = '0;
    logic signed [7:0] load_re = '0, load_im = '0;
    logic [BW-1:0] rbb_addr;
    logic signed [7:0] rbb_data;
    logic [IW-1:0] rbr_addr;
    logic signed [15:0] rbr_re, rbr_im;
    logic [IW-1:0] rd_idx = '0;
    logic signed [7:0] rd_re, rd_im;
    logic done;

    int ere [E], eim [E], nre [E], nim [E];
    int rbb [NB], rbrr [E], rbri [E];
    int n_chk = 0, n_err = 0;
    int unsigned seed = 32'h1234_5678;

    always #10 clk = ~clk;

    assign rbb_data = 8'(rbb[rbb_addr]);
    assign rbr_re   = 16'(rbrr[rbr_addr]);
    assign rbr_im   = 16'(rbri[rbr_addr]);

    sd_chan_est_update #(.ROWS(ROWS), .COLS(COLS), .SHIFT(SH), .RBR_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .load_en(load_en),
        .load_idx(load_idx), .load_re(load_re), .load_im(load_im),
        .rbb_addr(rbb_addr), .rbb_data(rbb_data), .rbr_addr(rbr_addr),
        .rbr_re(rbr_re), .rbr_im(rbr_im), .rd_idx(rd_idx),
        .rd_re(rd_re), .rd_im(rd_im), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp(input int v, input int lo, input int hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic int rnd8();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'($signed(seed[23:16]));
    endfunction

    function automatic int rnd16();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'($signed(seed[27:12]));
    endfunction

    // Reference for one plane, from R3..R5.
    task automatic model_plane(input int cur [E], input int rbr_p [E], output int nxt [E]);
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++) begin
                int acc, err, stp;
                acc = 0;
                for (int k = 0; k < COLS; k++)
                    acc = clamp(acc + cur[i*COLS+k] * rbb[k*COLS+j], -32768, 32767);
                err = clamp(acc - rbr_p[i*COLS+j], -32768, 32767);
                stp = clamp(err >>> SH, -128, 127);
                nxt[i*COLS+j] = clamp(cur[i*COLS+j] - stp, -128, 127);
            end
    endtask

    task automatic load_all();
        for (int n = 0; n < E; n++) begin
            @(negedge clk);
            load_en = 1'b1; load_idx = IW'(n);
            load_re = 8'(ere[n]); load_im = 8'(eim[n]);
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        for (int n = 0; n < E; n++) begin
            rd_idx = IW'(n);
            #1;
            chk(int'(rd_re) == ere[n], req, $sformatf("re[%0d]", n), int'(rd_re), ere[n]);
            chk(int'(rd_im) == eim[n], req, $sformatf("im[%0d]", n), int'(rd_im), eim[n]);
        end
    endtask

    // One pass; inject=1 pulses start and load mid-pass (R9).
    task automatic run_pass(input bit inject, input string req);
        int cyc;
        model_plane(ere, rbrr, nre);
        model_plane(eim, rbri, nim);
        rd_idx = '0;
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            if (inject && cyc == 3) begin
                start = 1'b1; load_en = 1'b1; load_idx = IW'(1);
                load_re = 8'(~ere[1]); load_im = 8'(~eim[1]);
                rd_idx = IW'(1);
            end
            if (inject && cyc == 4) begin
                start = 1'b0; load_en = 1'b0;
            end
            if (inject && cyc == 6) begin
                chk(int'(rd_re) == ere[1], "R9", "load ignored re", int'(rd_re), ere[1]);
                chk(int'(rd_im) == eim[1], "R6", "frozen im", int'(rd_im), eim[1]);
            end
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        chk(cyc == PASS_CYC, "R8", "cycles to done", cyc, PASS_CYC);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done pulse width", int'(done), 0);
        for (int n = 0; n < E; n++) begin ere[n] = nre[n]; eim[n] = nim[n]; end
        check_all(req);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int n = 0; n < E; n++) begin ere[n] = 0; eim[n] = 0; rbrr[n] = 0; rbri[n] = 0; end
        for (int n = 0; n < NB; n++) rbb[n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        check_all("R1");

        // R2: load and read back.
        for (int n = 0; n < E; n++) begin ere[n] = rnd8(); eim[n] = rnd8(); end
        load_all();
        check_all("R2");

        // R3/R5: positive accumulator clamp, then lower element clamp.
        for (int n = 0; n < E; n++) begin ere[n] = -128; eim[n] = -128; rbrr[n] = -1000; rbri[n] = 0; end
        for (int n = 0; n < NB; n++) rbb[n] = -128;
        load_all();
        run_pass(1'b0, "R5");

        // R3/R4: negative accumulator clamp, then upper element clamp.
        for (int n = 0; n < E; n++) begin ere[n] = 127; eim[n] = 127; rbrr[n] = 1000; rbri[n] = -32768; end
        for (int n = 0; n < NB; n++) rbb[n] = -128;
        load_all();
        run_pass(1'b0, "R4");

        // R4: small errors exercise rounding toward minus infinity.
        for (int n = 0; n < E; n++) begin ere[n] = 0; eim[n] = 0; rbrr[n] = n - 3; rbri[n] = 3 - n; end
        load_all();
        run_pass(1'b0, "R4");

        // R6/R9: ignored pulses during a pass.
        for (int n = 0; n < E; n++) begin ere[n] = rnd8(); eim[n] = rnd8(); rbrr[n] = rnd16(); rbri[n] = rnd16(); end
        for (int n = 0; n < NB; n++) rbb[n] = rnd8();
        load_all();
        run_pass(1'b1, "R6");

        // R7/R3: chained random passes, fresh matrices each time.
        for (int it = 0; it < 40; it++) begin
            for (int n = 0; n < E; n++) begin rbrr[n] = rnd16() >>> (it % 4); rbri[n] = rnd16() >>> 3; end
            for (int n = 0; n < NB; n++) rbb[n] = rnd8() >>> (it % 3);
            if (it % 10 == 0) begin
                for (int n = 0; n < E; n++) begin ere[n] = rnd8(); eim[n] = rnd8(); end
                load_all();
            end
            run_pass(1'b0, "R7");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule